// File: doc/BRIEF.md
# Read-Path Delay Compensation Calculator

This block turns the data-valid delay of an attached serial slave into the timing settings a serial-bus master needs for reading. It takes the slave's delay in nanoseconds and a flag that says whether the pins go through an extra routing matrix. That matrix adds 25 ns, which is two cycles of the 80 MHz base clock. It also takes the serial-clock divider chosen from that 80 MHz clock. From these it derives the smallest divider that still latches read data safely. For half-duplex transfers, where the read phase can be pushed back, it works out how many dummy serial-clock cycles to insert, and what residue of base cycles is left to compensate. For full-duplex transfers, where no dummy cycles are possible, it raises a flag when the chosen clock is too fast to read reliably.

All arithmetic is integer. The delay is quantised into base cycles, floor(delay / 12.5 ns), by dividing twice the delay by 25. The safe frequency is reported as a divider, so the frequency limit is 80 MHz divided by that value. A caller pulses `start` with the settings applied. It then waits for a one-cycle `done` pulse, after which the results hold until the next request. One serial subtract-and-count divider does both divisions, one after the other.

Top module: `mdc_calc`

## Requirements
- R1: After reset, `limit_div` is 1, `dummy_cycles`, `rem_cycles` and `fd_violation` are 0, and `busy` and `done` are low.
- R2: With no-dummy clear, `limit_div` equals q+1, where q = floor(2·path_ns / 25) and path_ns is the delay plus any routing addition. Delays of 0, 50 and 75 ns without routing give 1, 5 and 7.
- R3: With `via_matrix` high, 25 ns is added to the delay before quantising. 0 ns then gives 3 and 75 ns gives 9.
- R4: `fd_violation` is 1 exactly when `half_duplex` is 0, `no_dummy` is 0 and the effective divider is below q+1. Whenever `half_duplex` is 0, `dummy_cycles` and `rem_cycles` are 0.
- R5: In half duplex with no-dummy clear, D = floor(q / divider). `dummy_cycles` is D, and the residue r = q mod divider is reported as follows. If D is 0 or r is 0, `rem_cycles` is 0. If 2·r equals the divider, `rem_cycles` is -1 (two's complement), meaning half a serial clock. Otherwise `rem_cycles` is r.
- R6: With `no_dummy` high, `limit_div` is 1 and `fd_violation`, `dummy_cycles` and `rem_cycles` are all 0, whatever the delay.
- R7: A `sclk_div` value of 0 is treated as a divider of 1.
- R8: `dummy_cycles` saturates at 2^DUMMY_W−1 when D exceeds it.
- R9: A `start` seen while `busy` is high is ignored. The inputs are sampled only on the accepted `start`. Results hold unchanged while the block is idle.
- R10: `busy` goes high in the cycle after an accepted `start` and stays high until the result is ready. At that point `busy` falls and `done` pulses for exactly one cycle, with the results valid in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request pulse; inputs sampled here |
| delay_ns | input | DLY_W | Slave data-valid delay in ns |
| via_matrix | input | 1 | Pins routed through the matrix (+25 ns) |
| half_duplex | input | 1 | Transfer is half duplex (dummy cycles allowed) |
| no_dummy | input | 1 | Disable dummy insertion and frequency check |
| sclk_div | input | DIV_W | Chosen divider of the 80 MHz base clock (0 means 1) |
| busy | output | 1 | Calculation in progress |
| done | output | 1 | One-cycle result-ready pulse |
| limit_div | output | DLY_W+2 | Minimum safe divider for reading |
| dummy_cycles | output | DUMMY_W | Dummy serial-clock cycles before the read phase |
| rem_cycles | output | DIV_W+1 | Signed residue in base cycles; -1 means half a serial clock |
| fd_violation | output | 1 | Full-duplex read too fast for the delay |

## Verification
The bench builds the block with DLY_W=10 and DIV_W=8, but narrows DUMMY_W to 4. With that width, a 500 ns delay at divider 1 drives the dummy count past 15, so the saturation path is exercised alongside the plain quantisation check values. The full 10-bit delay range then reaches the largest quotient of 83. A reference model checks the held results on every idle clock, and it also covers a second `start` that arrives during a long calculation.

// File: rtl/mdc_pkg.sv
package mdc_pkg;

    // Extra delay of the routing matrix, in ns (two base cycles).
    localparam int ROUTE_NS  = 25;
    // Twice the 12.5 ns base period: floor(ns/12.5) == floor(2*ns/25).
    localparam int QUANT_DEN = 25;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_QUANT = 2'd1,
        ST_SPLIT = 2'd2
    } mdc_state_e;

    typedef struct packed {
        logic hd;   // half duplex
        logic nd;   // no-dummy override
    } mdc_mode_t;

endpackage

// File: rtl/mdc_serdiv.sv
// Serial divider by repeated subtraction; one quotient step per cycle.
module mdc_serdiv #(
    parameter int W = 12
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] num,
    input  logic [W-1:0] den,
    output logic         busy,
    output logic         done,
    output logic [W-1:0] quo,
    output logic [W-1:0] rem
);
    logic [W-1:0] den_r;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy  <= 1'b0;
            quo   <= '0;
            rem   <= '0;
            den_r <= '1;
        end else if (load) begin
            busy  <= 1'b1;
            quo   <= '0;
            rem   <= num;
            den_r <= den;
        end else if (busy) begin
            if (rem >= den_r) begin
                rem <= rem - den_r;
                quo <= quo + 1'b1;
            end else begin
                busy <= 1'b0;
            end
        end
    end

    // Quotient and remainder are final in the cycle this is high.
    assign done = busy && (rem < den_r);

endmodule

// File: rtl/mdc_result.sv
// Combinational shaping of the quotients into the reported results.
module mdc_result #(
    parameter int NW      = 12,
    parameter int W1      = 12,
    parameter int DIV_W   = 8,
    parameter int DUMMY_W = 8
) (
    input  logic [NW-1:0]          q,
    input  logic [W1-1:0]          dq,
    input  logic [W1-1:0]          dr,
    input  logic [DIV_W-1:0]       div_eff,
    input  mdc_pkg::mdc_mode_t     mode,
    output logic [NW-1:0]          limit,
    output logic [DUMMY_W-1:0]     dummy,
    output logic signed [DIV_W:0]  resid,
    output logic                   fdv
);
    localparam int CW = ((W1 > NW) ? W1 : NW) + 1;
    localparam logic [W1-1:0] DMAX = W1'((64'd1 << DUMMY_W) - 64'd1);

    logic [CW-1:0] need_c;
    logic [CW-1:0] div_c;
    logic [CW-1:0] dr2_c;
    logic          no_split;

    assign need_c   = CW'(q) + CW'(1);
    assign div_c    = CW'(div_eff);
    assign dr2_c    = CW'(dr) << 1;
    assign no_split = mode.nd || !mode.hd || (dq == '0);

    always_comb begin
        limit = mode.nd ? NW'(1) : NW'(need_c);
        fdv   = !mode.nd && !mode.hd && (div_c < need_c);
        dummy = '0;
        resid = '0;
        if (!no_split) begin
            dummy = (dq > DMAX) ? DMAX[DUMMY_W-1:0] : dq[DUMMY_W-1:0];
            if (dr == '0)
                resid = '0;
            else if (dr2_c == div_c)
                resid = '1;
            else
                resid = $signed({1'b0, dr[DIV_W-1:0]});
        end
    end

endmodule

// File: rtl/mdc_calc.sv
module mdc_calc
    import mdc_pkg::*;
#(
    parameter int DLY_W   = 10,
    parameter int DIV_W   = 8,
    parameter int DUMMY_W = 8
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  start,
    input  logic [DLY_W-1:0]      delay_ns,
    input  logic                  via_matrix,
    input  logic                  half_duplex,
    input  logic                  no_dummy,
    input  logic [DIV_W-1:0]      sclk_div,
    output logic                  busy,
    output logic                  done,
    output logic [DLY_W+1:0]      limit_div,
    output logic [DUMMY_W-1:0]    dummy_cycles,
    output logic signed [DIV_W:0] rem_cycles,
    output logic                  fd_violation
);
    localparam int NW = DLY_W + 2;
    localparam int W1 = (NW > DIV_W) ? NW : DIV_W;

    mdc_state_e       st;
    mdc_mode_t        mode_r;
    logic [DIV_W-1:0] div_r;
    logic [NW-1:0]    q_r;

    logic [NW-1:0]    path2;
    logic [DIV_W-1:0] div_in;
    logic             dv_load, dv_busy, dv_done;
    logic [W1-1:0]    dv_num, dv_den, dv_quo, dv_rem;

    logic [NW-1:0]          r_limit;
    logic [DUMMY_W-1:0]     r_dummy;
    logic signed [DIV_W:0]  r_resid;
    logic                   r_fdv;

    // Twice the path delay; divided by 25 it gives whole base cycles.
    assign path2  = {(NW-1)'(delay_ns) + (via_matrix ? (NW-1)'(ROUTE_NS) : '0), 1'b0};
    assign div_in = (sclk_div == '0) ? DIV_W'(1) : sclk_div;

    // One divider, used first for quantising and then for splitting.
    assign dv_load = ((st == ST_IDLE) && start) || ((st == ST_QUANT) && dv_done);
    assign dv_num  = (st == ST_IDLE) ? W1'(path2) : dv_quo;
    assign dv_den  = (st == ST_IDLE) ? W1'(QUANT_DEN) : W1'(div_r);

    mdc_serdiv #(.W(W1)) u_div (
        .clk  (clk),
        .rst  (rst),
        .load (dv_load),
        .num  (dv_num),
        .den  (dv_den),
        .busy (dv_busy),
        .done (dv_done),
        .quo  (dv_quo),
        .rem  (dv_rem)
    );

    mdc_result #(.NW(NW), .W1(W1), .DIV_W(DIV_W), .DUMMY_W(DUMMY_W)) u_res (
        .q       (q_r),
        .dq      (dv_quo),
        .dr      (dv_rem),
        .div_eff (div_r),
        .mode    (mode_r),
        .limit   (r_limit),
        .dummy   (r_dummy),
        .resid   (r_resid),
        .fdv     (r_fdv)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            st           <= ST_IDLE;
            mode_r       <= '0;
            div_r        <= DIV_W'(1);
            q_r          <= '0;
            done         <= 1'b0;
            limit_div    <= NW'(1);
            dummy_cycles <= '0;
            rem_cycles   <= '0;
            fd_violation <= 1'b0;
        end else begin
            done <= 1'b0;
            case (st)
                ST_IDLE: begin
                    if (start) begin
                        mode_r <= '{hd: half_duplex, nd: no_dummy};
                        div_r  <= div_in;
                        st     <= ST_QUANT;
                    end
                end
                ST_QUANT: begin
                    if (dv_done) begin
                        q_r <= dv_quo[NW-1:0];
                        st  <= ST_SPLIT;
                    end
                end
                ST_SPLIT: begin
                    if (dv_done) begin
                        limit_div    <= r_limit;
                        dummy_cycles <= r_dummy;
                        rem_cycles   <= r_resid;
                        fd_violation <= r_fdv;
                        done         <= 1'b1;
                        st           <= ST_IDLE;
                    end
                end
                default: st <= ST_IDLE;
            endcase
        end
    end

    assign busy = (st != ST_IDLE) || dv_busy;

endmodule

// File: rtl/mdc_calc_chk.sv
module mdc_calc_chk #(
    parameter int DLY_W   = 10,
    parameter int DIV_W   = 8,
    parameter int DUMMY_W = 8
) (
    input logic                  clk,
    input logic                  rst,
    input logic                  start,
    input logic                  busy,
    input logic                  done,
    input logic [DLY_W+1:0]      limit_div,
    input logic [DUMMY_W-1:0]    dummy_cycles,
    input logic signed [DIV_W:0] rem_cycles,
    input logic                  fd_violation
);
    a_r10_done_single: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    a_r10_done_idle: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy);

    a_r10_start_busy: assert property (@(posedge clk) disable iff (rst)
        (start && !busy) |=> busy);

    a_r2_limit_nonzero: assert property (@(posedge clk) disable iff (rst)
        done |-> (limit_div != '0));

    a_r4_fd_no_dummy: assert property (@(posedge clk) disable iff (rst)
        (done && fd_violation) |-> (dummy_cycles == '0 && rem_cycles == '0));

    a_r9_hold_idle: assert property (@(posedge clk) disable iff (rst)
        (!busy && !start) |=> ($stable(limit_div) && $stable(dummy_cycles)
                              && $stable(rem_cycles) && $stable(fd_violation)));
endmodule

bind mdc_calc mdc_calc_chk #(.DLY_W(DLY_W), .DIV_W(DIV_W), .DUMMY_W(DUMMY_W)) i_chk (
    .clk          (clk),
    .rst          (rst),
    .start        (start),
    .busy         (busy),
    .done         (done),
    .limit_div    (limit_div),
    .dummy_cycles (dummy_cycles),
    .rem_cycles   (rem_cycles),
    .fd_violation (fd_violation)
);

// File: tb/test_mdc_calc.sv
module test_mdc_calc;
    localparam int CLK_PERIOD = 10;
    localparam int DLY_W = 10;
    localparam int DIV_W = 8;
    localparam int DUMMY_W = 4;
    localparam int DMAX = (1 << DUMMY_W) - 1;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic start = 1'b0;
    logic [DLY_W-1:0] delay_ns = '0;
    logic via_matrix = 1'b0, half_duplex = 1'b0, no_dummy = 1'b0;
    logic [DIV_W-1:0] sclk_div = '0;
    logic busy, done, fd_violation;
    logic [DLY_W+1:0] limit_div;
    logic [DUMMY_W-1:0] dummy_cycles;
    logic signed [DIV_W:0] rem_cycles;

    int tests = 0, fails = 0, cycles = 0;
    int e_lim = 1, e_dum = 0, e_res = 0, e_fdv = 0;
    bit exp_valid = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    mdc_calc #(.DLY_W(DLY_W), .DIV_W(DIV_W), .DUMMY_W(DUMMY_W)) i_mdc_calc (
        .clk(clk), .rst(rst), .start(start), .delay_ns(delay_ns),
        .via_matrix(via_matrix), .half_duplex(half_duplex), .no_dummy(no_dummy),
        .sclk_div(sclk_div), .busy(busy), .done(done), .limit_div(limit_div),
        .dummy_cycles(dummy_cycles), .rem_cycles(rem_cycles), .fd_violation(fd_violation)
    );

    task automatic chk(string req, int act, int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Behavioural model taken from the requirements.
    task automatic model(int d, bit m, bit hd, bit nd, int div);
        int path, q, de, dd, r;
        path = d + (m ? 25 : 0);
        q = (2 * path) / 25;
        de = (div == 0) ? 1 : div;
        e_lim = nd ? 1 : q + 1;
        e_fdv = (!nd && !hd && de < q + 1) ? 1 : 0;
        e_dum = 0;
        e_res = 0;
        if (!nd && hd) begin
            dd = q / de;
            r = q % de;
            if (dd != 0) begin
                e_dum = (dd > DMAX) ? DMAX : dd;
                e_res = (r == 0) ? 0 : ((2 * r == de) ? -1 : r);
            end
        end
    endtask

    task automatic compare(string req);
        chk({req, " limit_div"}, int'(limit_div), e_lim);
        chk({req, " dummy_cycles"}, int'(dummy_cycles), e_dum);
        chk({req, " rem_cycles"}, int'($signed(rem_cycles)), e_res);
        chk({req, " fd_violation"}, int'(fd_violation), e_fdv);
    endtask

    task automatic wait_done();
        for (int n = 0; n < 2000 && !done; n++) @(negedge clk);
        chk("R10 done pulse", int'(done), 1);
        chk("R10 busy low at done", int'(busy), 0);
    endtask

    task automatic run(int d, bit m, bit hd, bit nd, int div, string req);
        @(negedge clk);
        exp_valid = 1'b0;
        delay_ns = DLY_W'(d); via_matrix = m; half_duplex = hd;
        no_dummy = nd; sclk_div = DIV_W'(div);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk("R10 busy after start", int'(busy), 1);
        wait_done();
        model(d, m, hd, nd, div);
        compare(req);
        exp_valid = 1'b1;
        @(negedge clk);
        chk("R10 done single cycle", int'(done), 0);
    endtask

    // Compare held results against the model on every idle clock (R9).
    always @(negedge clk) begin
        if (exp_valid && !rst && !busy && !done && !start)
            compare("R9 hold");
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", cycles, 100000);
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk("R1 limit_div", int'(limit_div), 1);
        chk("R1 dummy_cycles", int'(dummy_cycles), 0);
        chk("R1 rem_cycles", int'(rem_cycles), 0);
        chk("R1 fd_violation", int'(fd_violation), 0);
        chk("R1 busy", int'(busy), 0);
        chk("R1 done", int'(done), 0);

        // R2 quantisation check values
        run(0, 0, 0, 0, 1, "R2 0ns");
        chk("R2 0ns limit 1", int'(limit_div), 1);
        run(50, 0, 0, 0, 5, "R2 50ns");
        chk("R2 50ns limit 5", int'(limit_div), 5);
        run(75, 0, 0, 0, 7, "R2 75ns");
        chk("R4 75ns div7 no violation", int'(fd_violation), 0);
        // R3 routing matrix
        run(0, 1, 0, 0, 3, "R3 0ns matrix");
        chk("R3 0ns matrix limit 3", int'(limit_div), 3);
        run(75, 1, 0, 0, 9, "R3 75ns matrix");
        chk("R3 75ns matrix limit 9", int'(limit_div), 9);
        // R4 full-duplex violation boundary
        run(75, 0, 0, 0, 6, "R4 div6");
        chk("R4 div6 violation", int'(fd_violation), 1);
        run(75, 0, 0, 0, 4, "R4 div4");
        // R5 half-duplex split
        run(75, 0, 1, 0, 4, "R5 half-sclk residue");
        chk("R5 residue -1", int'($signed(rem_cycles)), -1);
        run(75, 0, 1, 0, 5, "R5 residue 1");
        run(75, 0, 1, 0, 3, "R5 exact");
        run(75, 0, 1, 0, 8, "R5 no dummy needed");
        run(1023, 1, 1, 0, 10, "R5 max delay");
        // R6 no-dummy override
        run(75, 1, 0, 1, 1, "R6 full duplex");
        run(300, 0, 1, 1, 2, "R6 half duplex");
        // R7 divider zero
        run(50, 0, 1, 0, 0, "R7 div0");
        chk("R7 div0 dummy 4", int'(dummy_cycles), 4);
        // R8 saturation
        run(500, 0, 1, 0, 1, "R8 saturate");
        chk("R8 dummy max", int'(dummy_cycles), DMAX);

        // R9 start during busy ignored, inputs sampled only at start
        @(negedge clk);
        exp_valid = 1'b0;
        delay_ns = 10'd500; via_matrix = 0; half_duplex = 1; no_dummy = 0; sclk_div = 8'd3;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        delay_ns = 10'd0; sclk_div = 8'd1; half_duplex = 0; via_matrix = 1;
        @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk("R9 still busy", int'(busy), 1);
        wait_done();
        model(500, 0, 1, 0, 3);
        compare("R9 first request kept");
        exp_valid = 1'b1;
        repeat (5) @(negedge clk);
        chk("R9 no second run", int'(busy), 0);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule